// File: doc/BRIEF.md
# Postfix Expression Stack Evaluator

This block evaluates integer arithmetic expressions supplied in postfix (reverse Polish) order. Tokens arrive one at a time over a valid/ready handshake; each token is an operand value, an addition operator, a multiplication operator, or an end marker that closes the current expression. Operands go onto an internal last-in first-out stack. Operators take the two newest entries off that stack, combine them and put the result back. A finite-state controller sequences this work, which a controller without a stack could not do for arbitrary nesting.

When the end marker is taken, the block reports the value on top of the stack as the result together with three error indications: a push was refused because the stack was full, an operator was refused because fewer than two entries were present, or the expression left other than exactly one entry behind. The stack and the error history are then cleared, so the next expression starts fresh. For example the stream `3 4 + 5 *` followed by the end marker yields 35, that is (3+4)*5.

Top module: `pfx_eval`

## Requirements
- R1: A token is taken on a rising clock edge where `tokValid` and `tokReady` are both high. `tokKind` encodes 0 = operand, 1 = add, 2 = multiply, 3 = end. An operand taken while the stack holds fewer than `STACK_DEPTH` (default 8) entries is pushed.
- R2: An add or multiply operator taken while at least two entries are present removes the two newest entries, combines them and pushes the result, which wraps modulo 2^`DATA_W` (default 16 bits).
- R3: An operand taken while the stack is full is discarded and the overflow indication of the current expression is set; the stack contents stay as they were.
- R4: An operator taken while fewer than two entries are present is discarded and the underflow indication of the current expression is set; the stack contents stay as they were.
- R5: After an operator that is carried out is taken, `tokReady` is low for exactly four cycles (take right operand, take left operand, compute, push back) and high again in the fifth.
- R6: In the cycle after the end marker is taken, `resValid` is high for one cycle and `resData` holds the stack top at that moment (0 if the stack is empty); `resOverflow` and `resUnderflow` report whether R3 or R4 occurred in that expression. All result outputs hold their value until the next end marker.
- R7: `resMalformed` is set with the result when the stack did not hold exactly one entry at the end marker.
- R8: Taking the end marker empties the stack and clears the overflow and underflow history, so the following expression is unaffected by earlier ones.
- R9: After reset `tokReady` is high, `resValid` is low and `resData`, `resMalformed`, `resOverflow`, `resUnderflow` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| tokValid | input | 1 | Token present on `tokKind`/`tokData` |
| tokReady | output | 1 | Block can take a token this cycle |
| tokKind | input | 2 | Token type: 0 operand, 1 add, 2 multiply, 3 end |
| tokData | input | DATA_W | Operand value, used when `tokKind` is 0 |
| resValid | output | 1 | One-cycle strobe: a result is being reported |
| resData | output | DATA_W | Value on the stack top at the end marker |
| resMalformed | output | 1 | Stack depth was not one at the end marker |
| resOverflow | output | 1 | An operand was refused because the stack was full |
| resUnderflow | output | 1 | An operator was refused for lack of operands |

## Verification
The assertions assume that `tokKind` and `tokData` are meaningful whenever `tokValid` is high and that a source never counts a token as taken unless `tokReady` was high at that edge. The bench drives every token on a falling edge, waits for `tokReady` before raising `tokValid`, and drops `tokValid` after exactly one accepting edge, so no token is ever offered during the four-cycle operator sequence. Pseudo-random expressions are built from all four token kinds, including deliberate overflow, underflow and unbalanced endings, and their expected results come from a stack model inside the bench.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [1:0] {
    TK_OPND = 2'd0,
    TK_ADD  = 2'd1,
    TK_MUL  = 2'd2,
    TK_END  = 2'd3
  } tokKind_e;

  // strobes from the controller to the datapath, one cycle each
  typedef struct packed {
    logic pushTok;   // push incoming operand
    logic popRight;  // pop newest entry into right operand register
    logic popLeft;   // pop next entry into left operand register
    logic calc;      // compute into result register
    logic pushRes;   // push computed value
    logic useMul;    // operation select for calc
    logic emit;      // report result, clear stack and history
    logic markOv;    // refused push
    logic markUn;    // refused operator
  } ctrlStrobes_t;

endpackage

// File: rtl/pfx_stack.sv
module pfx_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wData,
  output logic [W-1:0]                 topData,
  output logic [$clog2(DEPTH+1)-1:0]   depth
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrIdx;
  logic [AW-1:0] topIdx;

  assign wrIdx  = AW'(depth);
  assign topIdx = AW'(depth - CW'(1));

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && !clr && wrIdx == AW'(i)) mem[i] <= wData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     depth <= '0;
    else if (clr)  depth <= '0;
    else if (push) depth <= depth + CW'(1);
    else if (pop)  depth <= depth - CW'(1);
  end

  assign topData = (depth == '0) ? '0 : mem[topIdx];

  p_push_not_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    push |-> depth < CW'(DEPTH));

  p_pop_not_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> depth != '0);

  p_push_grows_r1: assert property (@(posedge clk) disable iff (!rstN)
    (push && !clr) |=> depth == $past(depth) + CW'(1));

  p_depth_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    depth <= CW'(DEPTH));

endmodule

// File: rtl/pfx_datapath.sv
module pfx_datapath
  import pfx_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                st,
  input  logic [W-1:0]                tokData,
  output logic [$clog2(DEPTH+1)-1:0]  depth,
  output logic                        resValid,
  output logic [W-1:0]                resData,
  output logic                        resMalformed,
  output logic                        resOverflow,
  output logic                        resUnderflow
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0] topData;
  logic [W-1:0] stackIn;
  logic [W-1:0] opRight;
  logic [W-1:0] opLeft;
  logic [W-1:0] calcOut;
  logic [W-1:0] aluOut;
  logic         ovSeen;
  logic         unSeen;

  assign stackIn = st.pushRes ? calcOut : tokData;

  pfx_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (st.emit),
    .push    (st.pushTok | st.pushRes),
    .pop     (st.popRight | st.popLeft),
    .wData   (stackIn),
    .topData (topData),
    .depth   (depth)
  );

  // arithmetic unit, result truncated to W bits (modulo 2^W)
  always_comb begin
    if (st.useMul) aluOut = W'(opLeft * opRight);
    else           aluOut = W'(opLeft + opRight);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opRight <= '0;
      opLeft  <= '0;
      calcOut <= '0;
    end else begin
      if (st.popRight) opRight <= topData;
      if (st.popLeft)  opLeft  <= topData;
      if (st.calc)     calcOut <= aluOut;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovSeen <= 1'b0;
      unSeen <= 1'b0;
    end else if (st.emit) begin
      ovSeen <= 1'b0;
      unSeen <= 1'b0;
    end else begin
      if (st.markOv) ovSeen <= 1'b1;
      if (st.markUn) unSeen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid     <= 1'b0;
      resData      <= '0;
      resMalformed <= 1'b0;
      resOverflow  <= 1'b0;
      resUnderflow <= 1'b0;
    end else begin
      resValid <= st.emit;
      if (st.emit) begin
        resData      <= topData;
        resMalformed <= (depth != CW'(1));
        resOverflow  <= ovSeen;
        resUnderflow <= unSeen;
      end
    end
  end

  p_result_after_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(st.emit));

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !st.emit |=> $stable(resData) && $stable(resMalformed));

  p_ov_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ovSeen && !st.emit) |=> ovSeen);

  p_history_cleared_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.emit |=> !ovSeen && !unSeen && depth == '0);

endmodule

// File: rtl/pfx_ctrl.sv
module pfx_ctrl
  import pfx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tokValid,
  input  logic [1:0]                  tokKind,
  output logic                        tokReady,
  input  logic [$clog2(DEPTH+1)-1:0]  depth,
  output ctrlStrobes_t                st
);

  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_POP_R, S_POP_L, S_CALC, S_PUSH
  } state_e;

  state_e   state, stateNxt;
  tokKind_e kindE;
  logic     accept;
  logic     isOp;
  logic     stkFull;
  logic     fewOps;
  logic     mulSel;

  assign kindE    = tokKind_e'(tokKind);
  assign tokReady = (state == S_IDLE);
  assign accept   = tokValid && tokReady;
  assign isOp     = (kindE == TK_ADD) || (kindE == TK_MUL);
  assign stkFull  = (depth == CW'(DEPTH));
  assign fewOps   = (depth < CW'(2));

  always_comb begin
    stateNxt = state;
    st       = '0;
    st.useMul = mulSel;
    unique case (state)
      S_IDLE: begin
        if (accept) begin
          unique case (kindE)
            TK_OPND: begin
              if (stkFull) st.markOv  = 1'b1;
              else         st.pushTok = 1'b1;
            end
            TK_ADD, TK_MUL: begin
              if (fewOps) st.markUn = 1'b1;
              else        stateNxt  = S_POP_R;
            end
            TK_END: st.emit = 1'b1;
            default: ;
          endcase
        end
      end
      S_POP_R: begin st.popRight = 1'b1; stateNxt = S_POP_L; end
      S_POP_L: begin st.popLeft  = 1'b1; stateNxt = S_CALC;  end
      S_CALC:  begin st.calc     = 1'b1; stateNxt = S_PUSH;  end
      S_PUSH:  begin st.pushRes  = 1'b1; stateNxt = S_IDLE;  end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      mulSel <= 1'b0;
    end else begin
      state <= stateNxt;
      if (accept && isOp) mulSel <= (kindE == TK_MUL);
    end
  end

  p_op_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isOp && !fewOps) |=> !tokReady);

  p_op_ends_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.pushRes |=> tokReady);

  p_no_underflow_pop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isOp && fewOps) |=> tokReady);

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.pushTok, st.popRight, st.popLeft, st.calc, st.pushRes, st.emit}));

endmodule

// File: rtl/pfx_eval.sv
module pfx_eval
  import pfx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokValid,
  output logic              tokReady,
  input  logic [1:0]        tokKind,
  input  logic [DATA_W-1:0] tokData,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic              resMalformed,
  output logic              resOverflow,
  output logic              resUnderflow
);

  localparam int CW = $clog2(STACK_DEPTH + 1);

  ctrlStrobes_t  strobes;
  logic [CW-1:0] depth;

  pfx_ctrl #(.DEPTH(STACK_DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tokValid (tokValid),
    .tokKind  (tokKind),
    .tokReady (tokReady),
    .depth    (depth),
    .st       (strobes)
  );

  pfx_datapath #(.W(DATA_W), .DEPTH(STACK_DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .st           (strobes),
    .tokData      (tokData),
    .depth        (depth),
    .resValid     (resValid),
    .resData      (resData),
    .resMalformed (resMalformed),
    .resOverflow  (resOverflow),
    .resUnderflow (resUnderflow)
  );

endmodule

// File: tb/pfx_eval_bench.sv
module pfx_eval_bench;

  localparam int W = 16;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         tokValid = 1'b0;
  logic         tokReady;
  logic [1:0]   tokKind = 2'd0;
  logic [W-1:0] tokData = '0;
  logic         resValid;
  logic [W-1:0] resData;
  logic         resMalformed;
  logic         resOverflow;
  logic         resUnderflow;

  always #4 clk = ~clk;

  pfx_eval u_pfx_eval (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokReady(tokReady),
    .tokKind(tokKind), .tokData(tokData), .resValid(resValid),
    .resData(resData), .resMalformed(resMalformed),
    .resOverflow(resOverflow), .resUnderflow(resUnderflow)
  );

  typedef struct {
    logic [W-1:0] data;
    logic         mal;
    logic         ov;
    logic         un;
    string        tag;
  } expect_t;

  expect_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // bench stack model, built from the requirements
  logic [W-1:0] mStk [D];
  int           mDepth = 0;
  bit           mOv = 0, mUn = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void modelTok(input int kind, input logic [W-1:0] val, input string tag);
    expect_t e;
    logic [W-1:0] r, l;
    case (kind)
      0: if (mDepth == D) mOv = 1; else begin mStk[mDepth] = val; mDepth++; end
      1, 2: if (mDepth < 2) mUn = 1;
            else begin
              r = mStk[mDepth-1]; l = mStk[mDepth-2]; mDepth -= 2;
              mStk[mDepth] = (kind == 1) ? W'(l + r) : W'(l * r);
              mDepth++;
            end
      default: begin
        e.data = (mDepth == 0) ? '0 : mStk[mDepth-1];
        e.mal = (mDepth != 1); e.ov = mOv; e.un = mUn; e.tag = tag;
        expQ.push_back(e);
        mDepth = 0; mOv = 0; mUn = 0;
      end
    endcase
  endfunction

  task automatic sendTok(input int kind, input logic [W-1:0] val, input string tag);
    while (!tokReady) @(negedge clk);
    tokValid = 1'b1; tokKind = 2'(kind); tokData = val;
    modelTok(kind, val, tag);
    @(negedge clk);
    tokValid = 1'b0; tokData = '0;
  endtask

  task automatic opnd(input logic [W-1:0] v); sendTok(0, v, ""); endtask
  task automatic endExpr(input string tag); sendTok(3, '0, tag); endtask

  // monitor: compare each reported result with the next expected item
  always @(negedge clk) begin
    expect_t e;
    if (rstN && resValid) begin
      if (expQ.size() == 0) begin
        check(0, "R6", "unexpected resValid", 1, 0);
      end else begin
        e = expQ.pop_front();
        check(resData == e.data, e.tag, "resData", resData, e.data);
        check(resMalformed == e.mal, "R7", {e.tag, " resMalformed"}, resMalformed, e.mal);
        check(resOverflow == e.ov, "R3", {e.tag, " resOverflow"}, resOverflow, e.ov);
        check(resUnderflow == e.un, "R4", {e.tag, " resUnderflow"}, resUnderflow, e.un);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    check(0, "WDOG", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(tokReady == 1'b1, "R9", "tokReady after reset", tokReady, 1);
    check(resValid == 1'b0, "R9", "resValid after reset", resValid, 0);
    check({resData, resMalformed, resOverflow, resUnderflow} == '0, "R9",
          "result outputs after reset", {resData, resMalformed, resOverflow, resUnderflow}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2: (3+4)*5
    opnd(3); opnd(4); sendTok(1, 0, ""); opnd(5); sendTok(2, 0, ""); endExpr("R2 (3+4)*5");
    // R1 single operand
    opnd(16'h1234); endExpr("R1 single operand");
    // R2 wraparound
    opnd(16'hFFFF); opnd(2); sendTok(1, 0, ""); endExpr("R2 add wrap");
    opnd(16'h0100); opnd(16'h0100); sendTok(2, 0, ""); endExpr("R2 mul wrap");
    // R6 hold: outputs stay after pulse
    repeat (3) @(negedge clk);
    check(resValid == 1'b0, "R6", "resValid one cycle only", resValid, 0);
    check(resData == 16'h0000, "R6", "resData held", resData, 0);
    // R4 underflow with one entry: entry preserved
    opnd(5); sendTok(1, 0, ""); endExpr("R4 underflow keeps entry");
    // R4 underflow empty + R7
    sendTok(2, 0, ""); endExpr("R4 underflow empty");
    // R3 overflow: ninth operand dropped
    for (int i = 1; i <= 9; i++) opnd(W'(i));
    endExpr("R3 overflow keeps top");
    // R8 clean expression after errors
    opnd(2); opnd(3); sendTok(2, 0, ""); endExpr("R8 fresh after errors");
    // R7 empty end, two entries left
    endExpr("R7 empty");
    opnd(1); opnd(2); endExpr("R7 two entries");
    // R2 full depth reduction
    for (int i = 1; i <= 8; i++) opnd(W'(i));
    for (int i = 0; i < 7; i++) sendTok(1, 0, "");
    endExpr("R2 deep sum");
    // R5 ready timing
    opnd(6); opnd(7);
    sendTok(2, 0, "");
    cnt = 0;
    while (!tokReady && cnt < 10) begin cnt++; @(negedge clk); end
    check(cnt == 4, "R5", "ready low cycles", cnt, 4);
    endExpr("R5 product");
    // random expressions
    for (int n = 0; n < 40; n++) begin
      int len = 1 + ($urandom % 14);
      for (int k = 0; k < len; k++) begin
        int r = $urandom % 10;
        if (r < 5) opnd(W'($urandom));
        else if (r < 8) sendTok(1, 0, "");
        else sendTok(2, 0, "");
        if (($urandom % 4) == 0) @(negedge clk);
      end
      endExpr("R2 random");
    end
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R6", "results outstanding", expQ.size(), 0);
    finishRun();
  end

endmodule